// File: doc/BRIEF.md
# Eight-Channel DMA Control and Status Registers

This block is the register front end of a multichannel DMA engine. A simple 32-bit register bus reaches it through a byte address, a write strobe, write data and combinational read data. Software uses it to set up each channel: the transfer mode, the direction, the interrupt enable and the descriptor words. It also uses it to start a channel and to service completions. The channel engines read their settings from dedicated output buses and receive start requests as one-cycle pulses.

Each channel engine reports a 2-bit activity state and pulses for completion and error. The block keeps the completion and error events as sticky flags that software clears by writing 1. It shows the live channel states next to the flags in one status word. A single interrupt line is raised while any flagged channel has its interrupt enabled.

Top module: `dma_csr`

## Requirements
- R1: After reset, every register reads as zero, `irq_o` is 0, and no start pulse, mode, direction or enable is driven.
- R2: Control word 0 (0x00) holds a 4-bit slice per channel at bit 4n. Bits 4n+1..4n are the mode driven on `ch_mode_o[2n+1:2n]`: 0 off, 1 linked descriptors, 2 single transfer. Bit 4n+2 is the direction on `ch_dir_o[n]`: 1 is memory to device, 0 is device to memory. Bit 4n+3 reads as 0.
- R3: Bits 7:0 of control word 2 (0x08) are the per-channel interrupt enables. They read back and are driven on `ch_irq_en_o`.
- R4: A write to control word 2 with bit 8+n set, while channel n reports state 0 (idle), gives a pulse on `ch_start_o[n]` for exactly the cycle after the write. Start bits always read as 0.
- R5: A start request for a channel whose state is not 0 produces no pulse on that channel.
- R6: A `ch_done_i[n]` pulse sets status word 0 (0x10) bit n. A `ch_err_i[n]` pulse sets bit 8+n. Both flags stay set until they are cleared.
- R7: Writing status word 0 clears each flag whose write-data bit is 1 and leaves the others. A set event in the same cycle as a clear wins.
- R8: Status word 0 bits 17+2n..16+2n show the live `ch_state_i` of channel n: 0 idle, 1 fetching a descriptor, 2 waiting, 3 transferring.
- R9: `irq_o` is high when some channel has both its completion flag and its interrupt enable set, and low otherwise.
- R10: Channel n's descriptor words sit at 0x20+16n: device address at +0, memory address at +4, size at +8, link at +0xC. They are read/write and are driven on the matching `ch_*_o` slice [32n+31:32n].
- R11: Control word 1 (0x04) is a 32-bit read/write word driven on `ctl1_o`.
- R12: Any other address reads as zero and a write to it changes nothing. This covers 0x0C, status word 1 at 0x14, 0x18, 0x1C, addresses past the last descriptor, and unaligned addresses. Reserved bits of control words 0 and 2 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Byte address of the register access |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| ch_state_i | input | 2*NCH | Per-channel activity state |
| ch_done_i | input | NCH | Per-channel completion pulse |
| ch_err_i | input | NCH | Per-channel error pulse |
| ch_mode_o | output | 2*NCH | Per-channel mode |
| ch_dir_o | output | NCH | Per-channel direction |
| ch_irq_en_o | output | NCH | Per-channel interrupt enable |
| ch_start_o | output | NCH | One-cycle start pulses |
| ctl1_o | output | 32 | Control word 1 contents |
| ch_dev_addr_o | output | 32*NCH | Descriptor device addresses |
| ch_mem_addr_o | output | 32*NCH | Descriptor memory addresses |
| ch_size_o | output | 32*NCH | Descriptor size words |
| ch_next_o | output | 32*NCH | Descriptor link words |
| irq_o | output | 1 | Combined interrupt |

## Verification
Some properties are checked on every cycle. A start pulse only ever follows a cycle in which its channel was idle. A completion event is never lost to a simultaneous clear. A clear without a new event removes the flag. The interrupt line stays low while all enables are off. Modes hold between writes, and start bits never read back as 1. Other behaviour only the bench scenarios can show: the field positions in each word, the descriptor address map, the live state packing, and the reserved addresses that leave other registers untouched.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  typedef enum logic [1:0] {
    CH_IDLE   = 2'd0,
    CH_FETCH  = 2'd1,
    CH_WAIT   = 2'd2,
    CH_XFER   = 2'd3
  } ch_state_e;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_CHAIN  = 2'd1,
    MODE_SINGLE = 2'd2,
    MODE_RSVD   = 2'd3
  } ch_mode_e;

  localparam int unsigned OFS_CTL0     = 32'h00;
  localparam int unsigned OFS_CTL1     = 32'h04;
  localparam int unsigned OFS_CTL2     = 32'h08;
  localparam int unsigned OFS_STS0     = 32'h10;
  localparam int unsigned DESC_BASE    = 32'h20;
  localparam int unsigned DESC_STRIDE  = 16;
  localparam int unsigned SLICE_W      = 4;
  localparam int unsigned START_LSB    = 8;
  localparam int unsigned ERR_LSB      = 8;
  localparam int unsigned STATE_LSB    = 16;
endpackage

// File: rtl/dma_csr_ctl.sv
module dma_csr_ctl
  import dma_csr_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl0_we_i,
  input  logic             ctl1_we_i,
  input  logic             ctl2_we_i,
  input  logic [31:0]      wdata_i,
  input  logic [2*NCH-1:0] ch_state_i,
  output logic [31:0]      ctl0_o,
  output logic [31:0]      ctl1_o,
  output logic [NCH-1:0]   irq_en_o,
  output logic [NCH-1:0]   start_o,
  output logic [2*NCH-1:0] mode_o,
  output logic [NCH-1:0]   dir_o
);
  logic [2:0]     slice_q [NCH];
  logic [31:0]    ctl1_q;
  logic [NCH-1:0] en_q;
  logic [NCH-1:0] start_q;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slice_q[n] <= '0;
        start_q[n] <= 1'b0;
      end else begin
        if (ctl0_we_i) slice_q[n] <= wdata_i[SLICE_W*n +: 3];
        start_q[n] <= ctl2_we_i && wdata_i[START_LSB+n]
                      && (ch_state_i[2*n +: 2] == CH_IDLE);
      end
    end
    assign mode_o[2*n +: 2] = slice_q[n][1:0];
    assign dir_o[n]         = slice_q[n][2];

    // R5: a pulse only follows a cycle where the channel was idle
    p_start_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_o[n] |-> $past(ch_state_i[2*n +: 2]) == CH_IDLE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl1_q <= '0;
      en_q   <= '0;
    end else begin
      if (ctl1_we_i) ctl1_q <= wdata_i;
      if (ctl2_we_i) en_q   <= wdata_i[NCH-1:0];
    end
  end

  always_comb begin
    ctl0_o = '0;
    for (int n = 0; n < NCH; n++) ctl0_o[SLICE_W*n +: SLICE_W] = {1'b0, slice_q[n]};
  end

  assign ctl1_o   = ctl1_q;
  assign irq_en_o = en_q;
  assign start_o  = start_q;

  p_mode_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !$past(ctl0_we_i) |-> $stable(mode_o) && $stable(dir_o));
endmodule

// File: rtl/dma_csr_sts.sv
module dma_csr_sts #(
  parameter int unsigned NCH = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_we_i,
  input  logic [NCH-1:0] clr_irq_i,
  input  logic [NCH-1:0] clr_err_i,
  input  logic [NCH-1:0] done_i,
  input  logic [NCH-1:0] err_i,
  input  logic [NCH-1:0] irq_en_i,
  output logic [NCH-1:0] irq_flag_o,
  output logic [NCH-1:0] err_flag_o,
  output logic           irq_o
);
  logic [NCH-1:0] irq_q, err_q;
  logic [NCH-1:0] clr_irq, clr_err;

  assign clr_irq = clr_we_i ? clr_irq_i : '0;
  assign clr_err = clr_we_i ? clr_err_i : '0;

  // set beats clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= '0;
      err_q <= '0;
    end else begin
      irq_q <= done_i | (irq_q & ~clr_irq);
      err_q <= err_i  | (err_q & ~clr_err);
    end
  end

  assign irq_flag_o = irq_q;
  assign err_flag_o = err_q;
  assign irq_o      = |(irq_q & irq_en_i);

  for (genvar n = 0; n < NCH; n++) begin : g_chk
    p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) && $past(done_i[n]) |-> irq_flag_o[n]);
    p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) && $past(err_flag_o[n]) && !$past(clr_we_i) |-> err_flag_o[n]);
    p_w1c_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) && $past(clr_we_i && clr_irq_i[n] && !done_i[n]) |-> !irq_flag_o[n]);
  end

  p_irq_masked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i == '0) |-> !irq_o);
endmodule

// File: rtl/dma_csr_desc.sv
module dma_csr_desc
  import dma_csr_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned AW  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic              hit_o,
  output logic [31:0]       rdata_o,
  output logic [32*NCH-1:0] dev_addr_o,
  output logic [32*NCH-1:0] mem_addr_o,
  output logic [32*NCH-1:0] size_o,
  output logic [32*NCH-1:0] next_o
);
  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [31:0]   word_q [NCH][4];
  logic [AW-1:0] off;
  logic [CW-1:0] ch_idx;
  logic [1:0]    fld;

  assign off    = addr_i - AW'(DESC_BASE);
  assign hit_o  = (addr_i >= AW'(DESC_BASE)) && (off < AW'(DESC_STRIDE*NCH))
                  && (addr_i[1:0] == 2'b00);
  assign ch_idx = off[CW+3:4];
  assign fld    = off[3:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int n = 0; n < NCH; n++)
        for (int k = 0; k < 4; k++) word_q[n][k] <= '0;
    end else if (we_i && hit_o) begin
      word_q[ch_idx][fld] <= wdata_i;
    end
  end

  assign rdata_o = hit_o ? word_q[ch_idx][fld] : '0;

  for (genvar n = 0; n < NCH; n++) begin : g_out
    assign dev_addr_o[32*n +: 32] = word_q[n][0];
    assign mem_addr_o[32*n +: 32] = word_q[n][1];
    assign size_o[32*n +: 32]     = word_q[n][2];
    assign next_o[32*n +: 32]     = word_q[n][3];
  end
endmodule

// File: rtl/dma_csr.sv
module dma_csr
  import dma_csr_pkg::*;
#(
  parameter int unsigned NCH = 8,  // status word layout allows up to 8
  parameter int unsigned AW  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [2*NCH-1:0]  ch_state_i,
  input  logic [NCH-1:0]    ch_done_i,
  input  logic [NCH-1:0]    ch_err_i,
  output logic [2*NCH-1:0]  ch_mode_o,
  output logic [NCH-1:0]    ch_dir_o,
  output logic [NCH-1:0]    ch_irq_en_o,
  output logic [NCH-1:0]    ch_start_o,
  output logic [31:0]       ctl1_o,
  output logic [32*NCH-1:0] ch_dev_addr_o,
  output logic [32*NCH-1:0] ch_mem_addr_o,
  output logic [32*NCH-1:0] ch_size_o,
  output logic [32*NCH-1:0] ch_next_o,
  output logic              irq_o
);
  logic        sel_ctl0, sel_ctl1, sel_ctl2, sel_sts0;
  logic [31:0] ctl0_w, ctl1_w, sts0_w, desc_rd;
  logic        desc_hit;
  logic [NCH-1:0] irq_en, irq_flag, err_flag;

  assign sel_ctl0 = addr_i == AW'(OFS_CTL0);
  assign sel_ctl1 = addr_i == AW'(OFS_CTL1);
  assign sel_ctl2 = addr_i == AW'(OFS_CTL2);
  assign sel_sts0 = addr_i == AW'(OFS_STS0);

  dma_csr_ctl #(.NCH(NCH)) u_ctl (
    .clk_i, .rst_ni,
    .ctl0_we_i  (we_i && sel_ctl0),
    .ctl1_we_i  (we_i && sel_ctl1),
    .ctl2_we_i  (we_i && sel_ctl2),
    .wdata_i,
    .ch_state_i,
    .ctl0_o     (ctl0_w),
    .ctl1_o     (ctl1_w),
    .irq_en_o   (irq_en),
    .start_o    (ch_start_o),
    .mode_o     (ch_mode_o),
    .dir_o      (ch_dir_o)
  );

  dma_csr_sts #(.NCH(NCH)) u_sts (
    .clk_i, .rst_ni,
    .clr_we_i   (we_i && sel_sts0),
    .clr_irq_i  (wdata_i[NCH-1:0]),
    .clr_err_i  (wdata_i[ERR_LSB +: NCH]),
    .done_i     (ch_done_i),
    .err_i      (ch_err_i),
    .irq_en_i   (irq_en),
    .irq_flag_o (irq_flag),
    .err_flag_o (err_flag),
    .irq_o
  );

  dma_csr_desc #(.NCH(NCH), .AW(AW)) u_desc (
    .clk_i, .rst_ni,
    .addr_i, .we_i, .wdata_i,
    .hit_o      (desc_hit),
    .rdata_o    (desc_rd),
    .dev_addr_o (ch_dev_addr_o),
    .mem_addr_o (ch_mem_addr_o),
    .size_o     (ch_size_o),
    .next_o     (ch_next_o)
  );

  always_comb begin
    sts0_w = '0;
    sts0_w[NCH-1:0]              = irq_flag;
    sts0_w[ERR_LSB +: NCH]       = err_flag;
    sts0_w[STATE_LSB +: 2*NCH]   = ch_state_i;
  end

  always_comb begin
    rdata_o = '0;
    if (sel_ctl0)      rdata_o = ctl0_w;
    else if (sel_ctl1) rdata_o = ctl1_w;
    else if (sel_ctl2) rdata_o[NCH-1:0] = irq_en;
    else if (sel_sts0) rdata_o = sts0_w;
    else if (desc_hit) rdata_o = desc_rd;
  end

  assign ctl1_o      = ctl1_w;
  assign ch_irq_en_o = irq_en;

  p_start_rd_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ctl2 |-> rdata_o[START_LSB +: NCH] == '0);
endmodule

// File: tb/dma_csr_test.sv
module dma_csr_test;
  localparam int NCH = 8;
  localparam int AW  = 8;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [AW-1:0]     addr = '0;
  logic              we = 1'b0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [2*NCH-1:0]  ch_state = '0;
  logic [NCH-1:0]    ch_done = '0;
  logic [NCH-1:0]    ch_err = '0;
  logic [2*NCH-1:0]  ch_mode;
  logic [NCH-1:0]    ch_dir, ch_irq_en, ch_start;
  logic [31:0]       ctl1;
  logic [32*NCH-1:0] dev_a, mem_a, size_w, next_w;
  logic              irq;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  dma_csr #(.NCH(NCH), .AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .ch_state_i(ch_state), .ch_done_i(ch_done), .ch_err_i(ch_err),
    .ch_mode_o(ch_mode), .ch_dir_o(ch_dir), .ch_irq_en_o(ch_irq_en),
    .ch_start_o(ch_start), .ctl1_o(ctl1), .ch_dev_addr_o(dev_a),
    .ch_mem_addr_o(mem_a), .ch_size_o(size_w), .ch_next_o(next_w), .irq_o(irq)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse(logic [NCH-1:0] done, logic [NCH-1:0] err);
    @(negedge clk);
    ch_done = done; ch_err = err;
    @(negedge clk);
    ch_done = '0; ch_err = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h00, d); check("R1", "ctl0", d, 0);
    rd(8'h04, d); check("R1", "ctl1", d, 0);
    rd(8'h08, d); check("R1", "ctl2", d, 0);
    rd(8'h10, d); check("R1", "sts0", d, 0);
    rd(8'h9C, d); check("R1", "desc", d, 0);
    check("R1", "irq/start/mode", {irq, ch_start, ch_mode}, 0);
  endtask

  task automatic t_ctl0;
    logic [31:0] d;
    wr(8'h00, 32'hF000_0061);
    rd(8'h00, d); check("R2", "ctl0 readback", d, 32'h7000_0061);
    check("R2", "mode", 32'(ch_mode), 32'h0000_C009);
    check("R2", "dir", 32'(ch_dir), 32'h0000_0082);
  endtask

  task automatic t_ctl1;
    logic [31:0] d;
    wr(8'h04, 32'hDEAD_BEEF);
    rd(8'h04, d); check("R11", "ctl1 readback", d, 32'hDEAD_BEEF);
    check("R11", "ctl1_o", ctl1, 32'hDEAD_BEEF);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wr(8'h08, 32'h0000_00A5);
    rd(8'h08, d); check("R3", "ctl2 readback", d, 32'h0000_00A5);
    check("R3", "irq_en_o", 32'(ch_irq_en), 32'h0000_00A5);
  endtask

  task automatic t_start;
    logic [31:0] d;
    wr(8'h08, 32'h0000_08A5);
    check("R4", "start pulse", 32'(ch_start), 32'h08);
    @(negedge clk);
    check("R4", "start one cycle", 32'(ch_start), 32'h00);
    rd(8'h08, d); check("R4", "start reads 0", d, 32'h0000_00A5);
  endtask

  task automatic t_start_busy;
    ch_state = 16'h0030;  // channel 2 transferring
    wr(8'h08, 32'h0000_06A5);
    check("R5", "busy start ignored", 32'(ch_start), 32'h02);
    ch_state = '0;
  endtask

  task automatic t_flags;
    logic [31:0] d;
    pulse(8'h21, 8'h20);
    rd(8'h10, d); check("R6", "flags set", d, 32'h0000_2021);
    repeat (3) @(negedge clk);
    rd(8'h10, d); check("R6", "flags sticky", d, 32'h0000_2021);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    wr(8'h10, 32'h0000_0021);
    rd(8'h10, d); check("R7", "w1c irq", d, 32'h0000_2000);
    wr(8'h10, 32'h0000_0000);
    rd(8'h10, d); check("R7", "write 0 keeps", d, 32'h0000_2000);
    wr(8'h10, 32'h0000_2000);
    rd(8'h10, d); check("R7", "w1c err", d, 32'h0);
  endtask

  task automatic t_collision;
    logic [31:0] d;
    @(negedge clk);
    addr = 8'h10; wdata = 32'h2; we = 1'b1; ch_done = 8'h02;
    @(negedge clk);
    we = 1'b0; ch_done = '0;
    rd(8'h10, d); check("R7", "set beats clear", d, 32'h0000_0002);
    wr(8'h10, 32'h2);
    rd(8'h10, d); check("R7", "later clear", d, 32'h0);
  endtask

  task automatic t_state;
    logic [31:0] d;
    logic [15:0] exp;
    for (int n = 0; n < NCH; n++) exp[2*n +: 2] = 2'(n % 4);
    ch_state = exp;
    rd(8'h10, d); check("R8", "state fields", d, {exp, 16'h0});
    ch_state = 16'h8000;
    rd(8'h10, d); check("R8", "state live", d, 32'h8000_0000);
    ch_state = '0;
  endtask

  task automatic t_irq;
    wr(8'h08, 32'h10);
    @(negedge clk); check("R9", "no flag", 32'(irq), 0);
    pulse(8'h10, 8'h00);
    check("R9", "enabled flag", 32'(irq), 1);
    pulse(8'h40, 8'h00);
    wr(8'h10, 32'h10);
    check("R9", "masked flag", 32'(irq), 0);
    wr(8'h08, 32'h40);
    check("R9", "enable pending", 32'(irq), 1);
    wr(8'h10, 32'hFF);
    check("R9", "all cleared", 32'(irq), 0);
  endtask

  task automatic t_desc;
    logic [31:0] d;
    wr(8'h20, 32'h1111_0000);
    wr(8'h24, 32'h2222_0004);
    wr(8'h58, 32'h0000_3123);
    wr(8'h9C, 32'h4444_000C);
    rd(8'h20, d); check("R10", "ch0 dev", d, 32'h1111_0000);
    rd(8'h24, d); check("R10", "ch0 mem", d, 32'h2222_0004);
    rd(8'h58, d); check("R10", "ch3 size", d, 32'h0000_3123);
    rd(8'h9C, d); check("R10", "ch7 next", d, 32'h4444_000C);
    check("R10", "dev_o ch0", dev_a[31:0], 32'h1111_0000);
    check("R10", "mem_o ch0", mem_a[31:0], 32'h2222_0004);
    check("R10", "size_o ch3", size_w[3*32 +: 32], 32'h0000_3123);
    check("R10", "next_o ch7", next_w[7*32 +: 32], 32'h4444_000C);
    check("R10", "dev_o ch1 untouched", dev_a[32 +: 32], 32'h0);
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    logic [AW-1:0] rsv [7] = '{8'h0C, 8'h14, 8'h18, 8'h1C, 8'hA0, 8'h22, 8'hFC};
    foreach (rsv[i]) wr(rsv[i], 32'hFFFF_FFFF);
    foreach (rsv[i]) begin
      rd(rsv[i], d); check("R12", $sformatf("addr 0x%02h reads 0", rsv[i]), d, 0);
    end
    rd(8'h04, d); check("R12", "ctl1 untouched", d, 32'hDEAD_BEEF);
    rd(8'h20, d); check("R12", "desc untouched", d, 32'h1111_0000);
    rd(8'h10, d); check("R12", "sts untouched", d, 32'h0);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); check("R12", "ctl0 reserved bits", d, 32'h7777_7777);
    wr(8'h08, 32'hFFFF_00FF);
    rd(8'h08, d); check("R12", "ctl2 reserved bits", d, 32'h0000_00FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_ctl0();
    t_ctl1();
    t_enable();
    t_start();
    t_start_busy();
    t_flags();
    t_w1c();
    t_collision();
    t_state();
    t_irq();
    t_desc();
    t_reserved();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule